// File: doc/BRIEF.md
# I2C Target with Busy-Marker Reads

This block is an I2C target that works from the system clock. It oversamples SCL and SDA through synchronizers and detects START, STOP and repeated START conditions on the synchronized lines. Its 7-bit address has a fixed upper part. The two lowest address bits come from strap inputs, so four targets can share one bus. On a write transfer, each data byte is acknowledged and handed to the core on a one-cycle strobe.

On a read transfer, the block never stretches SCL. The first byte it returns is a marker taken from the core's busy input. The marker is 0x00 when the core is idle, which means the bytes that follow are valid. It is 0xFF when the core is busy, which tells the master to repeat its command write and read again. After the marker, each byte comes from the core's read-data input, and the block pulses a take strobe so the core can move to the next byte.

SDA is driven open-drain: the output enable can only pull the line low. The block has no SCL output.

Top module: `i2c_marker_target`

## Requirements
- R1: The address byte is the 7-bit address, MSB first, followed by R/W. The address is binary 10000 followed by strap_i[1:0], which gives 0x40 to 0x43. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R2: On a write (R/W=0), each following 8-bit data byte is received MSB first and acknowledged. The byte appears on wr_data with a single-cycle wr_valid pulse, and bytes are presented in bus order.
- R3: On a read (R/W=1), the first byte returned is 0x00 if core_busy was low when the address was accepted.
- R4: The first byte returned is 0xFF if core_busy was high when the address was accepted. The marker does not change if core_busy changes later in the same read.
- R5: After the master ACKs a read byte, the next byte is taken from rd_data and sent MSB first. A single-cycle rd_take pulse marks each byte loaded this way.
- R6: A master NACK after a read byte ends the transmission. SDA stays released and no further rd_take pulses occur until the next START.
- R7: A repeated START ends the current transfer and starts a new address phase without a STOP.
- R8: After a non-matching address, the block gives no ACK, produces no wr_valid and does not drive SDA until the next START or STOP.
- R9: After reset, and after any STOP, sda_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, pulls SDA low |
| strap_i | input | 2 | Low two address bits |
| core_busy | input | 1 | Core busy flag, sampled into the read marker |
| rd_data | input | 8 | Next byte to transmit on a read |
| rd_take | output | 1 | Pulse: rd_data has been loaded for transmission |
| wr_data | output | 8 | Last received write byte |
| wr_valid | output | 1 | Pulse: wr_data holds a new byte |

## Verification
The bench tries every strap setting, plus addresses that differ from the strapped one in a single low bit and in an upper bit. A decoder that ignored the straps, or compared too few bits, would acknowledge a foreign address. It lowers core_busy right after the address is accepted, so a marker taken too late would read 0x00 instead of 0xFF. It also clocks extra bits after a master NACK: a target that kept transmitting would pull SDA low or fetch another byte. Finally, it issues a repeated START straight after a write, and an ignored address followed by a repeated START to the real address, which catches a state machine that needs a STOP to recover.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2ct_linecond.sv
module i2ct_linecond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign scl_rise = scl & ~scl_p;
  assign scl_fall = ~scl & scl_p;
  assign start_c  = scl & scl_p & sda_p & ~sda;
  assign stop_c   = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_s,
  input  logic [DATA_W-2:0] my_addr,
  input  logic              core_busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              rd_take,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_valid
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] tx;
  logic              rw;
  logic              busy_lat;
  logic              nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      busy_lat <= 1'b0;
      nack     <= 1'b0;
      sda_oe   <= 1'b0;
      rd_take  <= 1'b0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_take  <= 1'b0;
      if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && cnt != CNT_FULL) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              if (shreg[DATA_W-1:1] == my_addr) begin
                sda_oe   <= 1'b1;
                rw       <= shreg[0];
                busy_lat <= core_busy;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= {DATA_W{busy_lat}};
                sda_oe <= ~busy_lat;
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && cnt != CNT_FULL) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              sda_oe   <= 1'b1;
              wr_data  <= shreg;
              wr_valid <= 1'b1;
              state    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                tx     <= {tx[DATA_W-2:0], 1'b0};
                sda_oe <= ~tx[DATA_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end else begin
                tx      <= rd_data;
                rd_take <= 1'b1;
                sda_oe  <= ~rd_data[DATA_W-1];
                cnt     <= '0;
                state   <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_marker_target.sv
module i2c_marker_target #(
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 2,
  parameter int STAGES  = 2,
  parameter logic [DATA_W-2-STRAP_W:0] ADDR_HI = 5'b10000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               core_busy,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               rd_take,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_valid
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic [DATA_W-2:0] my_addr;

  assign my_addr = {ADDR_HI, strap_i};

  i2ct_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .dout ({scl_s, sda_s})
  );

  i2ct_linecond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl      (scl_s),
    .sda      (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2ct_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .sda_s     (sda_s),
    .my_addr   (my_addr),
    .core_busy (core_busy),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .rd_take   (rd_take),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid)
  );
endmodule

// File: rtl/i2ct_check.sv
module i2ct_check #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              wr_valid,
  input logic              rd_take,
  input logic [DATA_W-1:0] rd_data,
  input logic              stop_c,
  input logic              scl_s
);
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!sda_oe && !wr_valid && !rd_take));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe);

  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  p_take_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> !rd_take);

  p_take_msb_r5: assert property (@(posedge clk) disable iff (rst)
    rd_take |-> (sda_oe == !$past(rd_data[DATA_W-1])));

  p_drive_scl_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_marker_target i2ct_check #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .rd_take  (rd_take),
  .rd_data  (rd_data),
  .stop_c   (stop_c),
  .scl_s    (scl_s)
);

// File: tb/i2c_marker_target_tb.sv
module i2c_marker_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_rel = 1'b1;
  logic [1:0] strap = 2'd0;
  logic       core_busy = 1'b0;
  logic [7:0] rd_data;
  logic       sda_oe, rd_take, wr_valid;
  logic [7:0] wr_data;
  logic       sda_line;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  int take_cnt = 0;
  logic [7:0] wr_log [16];

  assign sda_line = m_rel & ~sda_oe;

  function automatic logic [7:0] core_byte(input int idx);
    return 8'((idx * 37 + 8'h5A) & 8'hFF);
  endfunction

  assign rd_data = core_byte(take_cnt);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_marker_target u_dut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .strap_i   (strap),
    .core_busy (core_busy),
    .rd_data   (rd_data),
    .rd_take   (rd_take),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid) begin
        wr_log[wr_cnt % 16] = wr_data;
        wr_cnt = wr_cnt + 1;
      end
      if (rd_take) take_cnt = take_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic v, output logic s);
    m_rel = v; wq();
    scl = 1'b1; wq();
    s = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_start();
    m_rel = 1'b1; wq();
    scl = 1'b1; wq();
    m_rel = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_rel = 1'b0; wq();
    scl = 1'b1; wq();
    m_rel = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, s);
      v = {v[6:0], s};
    end
    bit_cycle(~ack, s);
  endtask

  // strap[17:16], addr[15:9], data[8:1], expected ack[0]
  localparam logic [17:0] VEC [7] = '{
    {2'd0, 7'h40, 8'hA5, 1'b1},
    {2'd1, 7'h41, 8'h3C, 1'b1},
    {2'd2, 7'h42, 8'h00, 1'b1},
    {2'd3, 7'h43, 8'hFF, 1'b1},
    {2'd0, 7'h41, 8'h77, 1'b0},
    {2'd3, 7'h42, 8'h11, 1'b0},
    {2'd1, 7'h51, 8'h22, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] v;
    int         n0, t0;

    repeat (4) @(negedge clk);
    chk("R9 reset sda_oe", sda_oe, 0);
    chk("R9 reset wr_valid", wr_valid, 0);
    chk("R9 reset rd_take", rd_take, 0);
    rst = 1'b0;
    wq();

    // Vector walk: address match per strap, single-byte write
    for (int k = 0; k < 7; k++) begin
      strap = VEC[k][17:16];
      wq();
      n0 = wr_cnt;
      i2c_start();
      wr_byte({VEC[k][15:9], 1'b0}, ack);
      chk("R1 address ack", ack, VEC[k][0]);
      wr_byte(VEC[k][8:1], ack);
      if (VEC[k][0]) begin
        chk("R2 data ack", ack, 1);
        chk("R2 byte count", wr_cnt - n0, 1);
        chk("R2 byte value", wr_log[n0 % 16], VEC[k][8:1]);
      end else begin
        chk("R8 no data ack", ack, 0);
        chk("R8 no wr_valid", wr_cnt - n0, 0);
      end
      i2c_stop();
      wq();
      chk("R9 released after stop", sda_oe, 0);
    end

    // R2: multi-byte write order
    strap = 2'd2;
    wq();
    n0 = wr_cnt;
    i2c_start();
    wr_byte(8'h84, ack);
    wr_byte(8'h12, ack); chk("R2 ack b0", ack, 1);
    wr_byte(8'h80, ack); chk("R2 ack b1", ack, 1);
    wr_byte(8'h01, ack); chk("R2 ack b2", ack, 1);
    i2c_stop();
    chk("R2 count", wr_cnt - n0, 3);
    chk("R2 order b0", wr_log[n0 % 16], 8'h12);
    chk("R2 order b1", wr_log[(n0 + 1) % 16], 8'h80);
    chk("R2 order b2", wr_log[(n0 + 2) % 16], 8'h01);

    // R3/R5: command write then idle read
    i2c_start();
    wr_byte(8'h84, ack);
    wr_byte(8'h05, ack);
    i2c_stop();
    t0 = take_cnt;
    i2c_start();
    wr_byte(8'h85, ack);
    chk("R1 read address ack", ack, 1);
    rd_byte(1'b1, v); chk("R3 marker valid", v, 8'h00);
    rd_byte(1'b1, v); chk("R5 data byte 0", v, core_byte(t0));
    rd_byte(1'b0, v); chk("R5 data byte 1", v, core_byte(t0 + 1));
    i2c_stop();
    chk("R5 take count", take_cnt - t0, 2);

    // R4: busy at address, cleared right after
    core_busy = 1'b1;
    i2c_start();
    wr_byte(8'h85, ack);
    core_busy = 1'b0;
    t0 = take_cnt;
    rd_byte(1'b1, v); chk("R4 marker busy", v, 8'hFF);
    rd_byte(1'b0, v); chk("R4 data after busy", v, core_byte(t0));
    i2c_stop();

    // R6: NACK on marker, then extra clocks
    t0 = take_cnt;
    i2c_start();
    wr_byte(8'h85, ack);
    rd_byte(1'b0, v); chk("R6 marker", v, 8'h00);
    rd_byte(1'b0, v); chk("R6 released after nack", v, 8'hFF);
    chk("R6 no take after nack", take_cnt - t0, 0);
    i2c_stop();

    // R7: write then repeated start into read
    n0 = wr_cnt;
    i2c_start();
    wr_byte(8'h84, ack);
    wr_byte(8'h9A, ack);
    i2c_start();
    wr_byte(8'h85, ack);
    chk("R7 ack after repeated start", ack, 1);
    rd_byte(1'b0, v); chk("R7 marker", v, 8'h00);
    i2c_stop();
    chk("R7 write captured", wr_log[n0 % 16], 8'h9A);

    // R8 then R7: ignored address, recover via repeated start
    n0 = wr_cnt;
    i2c_start();
    wr_byte(8'h88, ack); chk("R8 foreign address nack", ack, 0);
    wr_byte(8'h00, ack); chk("R8 ignored byte nack", ack, 0);
    i2c_start();
    wr_byte(8'h84, ack); chk("R7 recover ack", ack, 1);
    wr_byte(8'h5E, ack);
    i2c_stop();
    chk("R8 only one byte seen", wr_cnt - n0, 1);
    chk("R7 recovered byte", wr_log[n0 % 16], 8'h5E);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule